// File: doc/BRIEF.md
# Debug Address/Data Comparator with Halt Request

This block watches the processor's bus and raises a halt request when a programmed condition is met. It holds two comparator units. Each unit compares the access address and the access data against programmed values, under masks in which a 1 bit means "ignore this bit". Each unit is set to one of two modes. In breakpoint mode it fires on instruction fetches. In watchpoint mode it fires on data reads, data writes, or both. An external debug-request pin, which may be asynchronous to the block clock, can also halt the processor.

Every register is reached through a serial shift path. A TAP-style controller, which sits outside this block, drives it with capture, shift and update strobes in the block clock domain. A packet is 38 bits long and goes in LSB first: 32 data bits, then a 5-bit register address, then a direction bit. A write takes effect on the update strobe. A read is done in two steps. An update with the direction bit at 0 selects the register. The next capture loads that register's value into the shift path, and it is then shifted out on `scan_tdo`.

The halt cause is recorded in a sticky status register, which software clears. The status is also brought out on `halt_cause`, and `halt_req` is the OR of its bits.

Top module: `dbgcmp_top`

## Requirements
- R1: After reset, `halt_req` and `halt_cause` are 0, every unit register reads 0 (both units disabled), and the global control register reads 1 (external request enabled).
- R2: A packet is shifted LSB first through `scan_tdi`, with bits [31:0] data, [36:32] register address and [37] direction (1 = write). A write changes the addressed register only on the cycle where `scan_update` is high.
- R3: An update with bit [37] = 0 selects a register. The next `scan_capture` loads that register's value so that bit 0 appears first on `scan_tdo`, and each shift then presents the next bit.
- R4: Register map: unit u uses base 8·u. At +0 is the address value, +1 the address mask, +2 the data value, +3 the data mask and +4 the unit control. A unit matches only if every address bit whose mask bit is 0 equals the value bit.
- R5: The same rule applies to `bus_data` against the data value and data mask. A data bit whose mask bit is 1 is ignored.
- R6: Unit control bit 0 is enable and bit 1 is mode (0 = breakpoint, 1 = watchpoint). A breakpoint unit matches only accesses with `bus_fetch` = 1.
- R7: A watchpoint unit matches only accesses with `bus_fetch` = 0. Unit control bit 2 selects the direction (1 = write, 0 = read). When unit control bit 3 is 1, either direction matches.
- R8: A unit whose enable bit is 0 never matches, whatever its other registers hold.
- R9: `ext_dbg_req` passes through a two-flop synchronizer. A pulse sampled at edge k sets cause bit 2 at edge k+2, but only while global control (address 16) bit 0 is 1.
- R10: The status register at address 17 holds cause bits 0 (unit 0), 1 (unit 1) and 2 (external request). A set bit stays set until a status write with a 1 in that bit position clears it.
- R11: A matching valid access at edge k sets its cause bit and `halt_req` at that same edge, and `halt_req` always equals the OR of `halt_cause`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_capture | input | 1 | Load the selected register into the shift path |
| scan_shift | input | 1 | Shift the path by one bit toward `scan_tdo` |
| scan_update | input | 1 | Apply the shifted packet |
| scan_tdi | input | 1 | Serial data in |
| scan_tdo | output | 1 | Serial data out (LSB of the shift path) |
| bus_valid | input | 1 | An access is present this cycle |
| bus_addr | input | 32 | Access address |
| bus_data | input | 32 | Access data or fetched instruction word |
| bus_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| bus_write | input | 1 | 1 = data write, 0 = data read |
| ext_dbg_req | input | 1 | Asynchronous external debug request |
| halt_req | output | 1 | Halt request to the processor |
| halt_cause | output | 3 | Sticky cause: bit0 unit 0, bit1 unit 1, bit2 external |

## Verification
The bench puts addresses just inside and just outside a masked range against a breakpoint. A unit that applied the mask wrongly would either miss the in-range fetch or fire on the neighbour. It presents a data read and a fetch to units in the other mode. A design that ignored the mode or the direction bit would raise a false halt there. It checks that a data mismatch confined to unmasked bits is enough to suppress a watchpoint, and that cause bits persist over idle cycles until a targeted clear. A non-sticky status would drop the cause early. The external request is sampled exactly two edges after the pin pulses, then again with the request disabled. A missing synchronizer stage, or a missing gate, shows up as an early or unwanted cause bit.

// File: rtl/dbgcmp_pkg.sv
package dbgcmp_pkg;
  localparam int RA_W       = 5;   // register address width in a packet
  localparam int UNIT_SPAN  = 8;   // address stride between units
  localparam int SEL_W      = 3;   // register select width inside a unit

  typedef enum logic [SEL_W-1:0] {
    SEL_AVAL = 3'd0,
    SEL_AMSK = 3'd1,
    SEL_DVAL = 3'd2,
    SEL_DMSK = 3'd3,
    SEL_CTRL = 3'd4
  } unit_sel_e;

  localparam logic [RA_W-1:0] GCTRL_ADDR = 5'd16;
  localparam logic [RA_W-1:0] STAT_ADDR  = 5'd17;

  // unit control bit positions
  localparam int UC_EN     = 0;
  localparam int UC_WP     = 1;
  localparam int UC_WR     = 2;
  localparam int UC_ANYDIR = 3;
  localparam int UC_W      = 4;
endpackage

// File: rtl/dbgcmp_sync.sv
module dbgcmp_sync (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  logic stage1_q, stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/dbgcmp_scan.sv
module dbgcmp_scan #(
  parameter int DW   = 32,
  parameter int RA_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            capture,
  input  logic            shift,
  input  logic            update,
  input  logic            tdi,
  input  logic [DW-1:0]   cap_data,
  output logic            tdo,
  output logic            wr_stb,
  output logic [RA_W-1:0] wr_addr,
  output logic [DW-1:0]   wr_data,
  output logic [RA_W-1:0] rd_addr
);
  localparam int PW = DW + RA_W + 1;

  logic [PW-1:0]   chain_q;
  logic [RA_W-1:0] rd_sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q  <= '0;
      rd_sel_q <= '0;
    end else begin
      if (capture)
        chain_q <= {1'b0, rd_sel_q, cap_data};
      else if (shift)
        chain_q <= {tdi, chain_q[PW-1:1]};
      if (update && !chain_q[PW-1])
        rd_sel_q <= chain_q[DW +: RA_W];
    end
  end

  assign tdo     = chain_q[0];
  assign wr_stb  = update && chain_q[PW-1];
  assign wr_addr = chain_q[DW +: RA_W];
  assign wr_data = chain_q[DW-1:0];
  assign rd_addr = rd_sel_q;

  // R3: the first bit out after a capture is bit 0 of the captured register
  a_r3_capture_lsb: assert property (@(posedge clk) disable iff (rst)
    capture |=> (tdo == $past(cap_data[0])));
endmodule

// File: rtl/dbgcmp_unit.sv
module dbgcmp_unit
  import dbgcmp_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [DW-1:0]    wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [DW-1:0]    rd_data,
  input  logic             bus_valid,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_data,
  input  logic             bus_fetch,
  input  logic             bus_write,
  output logic             hit
);
  logic [AW-1:0]   aval_q, amsk_q;
  logic [DW-1:0]   dval_q, dmsk_q;
  logic [UC_W-1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      aval_q <= '0;
      amsk_q <= '0;
      dval_q <= '0;
      dmsk_q <= '0;
      ctrl_q <= '0;
    end else if (wr_en) begin
      case (unit_sel_e'(wr_sel))
        SEL_AVAL: aval_q <= AW'(wr_data);
        SEL_AMSK: amsk_q <= AW'(wr_data);
        SEL_DVAL: dval_q <= wr_data;
        SEL_DMSK: dmsk_q <= wr_data;
        SEL_CTRL: ctrl_q <= wr_data[UC_W-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (unit_sel_e'(rd_sel))
      SEL_AVAL: rd_data = DW'(aval_q);
      SEL_AMSK: rd_data = DW'(amsk_q);
      SEL_DVAL: rd_data = dval_q;
      SEL_DMSK: rd_data = dmsk_q;
      SEL_CTRL: rd_data = DW'(ctrl_q);
      default:  rd_data = '0;
    endcase
  end

  logic addr_ok, data_ok, kind_ok, dir_ok;

  always_comb begin
    addr_ok = ((bus_addr ^ aval_q) & ~amsk_q) == '0;
    data_ok = ((bus_data ^ dval_q) & ~dmsk_q) == '0;
    dir_ok  = ctrl_q[UC_ANYDIR] || (bus_write == ctrl_q[UC_WR]);
    kind_ok = ctrl_q[UC_WP] ? (!bus_fetch && dir_ok) : bus_fetch;
    hit     = bus_valid && ctrl_q[UC_EN] && addr_ok && data_ok && kind_ok;
  end

  // R8: a disabled unit stays silent
  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[UC_EN] |-> !hit);
  // R4: no match without a valid access
  a_r4_needs_valid: assert property (@(posedge clk) disable iff (rst)
    hit |-> bus_valid);
endmodule

// File: rtl/dbgcmp_top.sv
module dbgcmp_top
  import dbgcmp_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int NUM_UNITS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scan_capture,
  input  logic             scan_shift,
  input  logic             scan_update,
  input  logic             scan_tdi,
  output logic             scan_tdo,
  input  logic             bus_valid,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_data,
  input  logic             bus_fetch,
  input  logic             bus_write,
  input  logic             ext_dbg_req,
  output logic             halt_req,
  output logic [NUM_UNITS:0] halt_cause
);
  localparam int NC    = NUM_UNITS + 1;
  localparam int UHI_W = RA_W - SEL_W;

  logic            wr_stb;
  logic [RA_W-1:0] wr_addr, rd_addr;
  logic [DW-1:0]   wr_data, cap_data;

  logic [NUM_UNITS-1:0] unit_hit;
  logic [DW-1:0]        unit_rd [NUM_UNITS];

  logic ext_sync;
  logic ext_en_q;
  logic [NC-1:0] stat_q, stat_nxt, set_v, clr_v;
  logic halt_q;

  dbgcmp_scan #(.DW(DW), .RA_W(RA_W)) u_scan (
    .clk(clk), .rst(rst),
    .capture(scan_capture), .shift(scan_shift), .update(scan_update),
    .tdi(scan_tdi), .cap_data(cap_data), .tdo(scan_tdo),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr)
  );

  dbgcmp_sync u_sync (
    .clk(clk), .rst(rst), .async_in(ext_dbg_req), .sync_out(ext_sync)
  );

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic sel_me;
    assign sel_me = (wr_addr[RA_W-1:SEL_W] == UHI_W'(u)) &&
                    (wr_addr[SEL_W-1:0] <= SEL_W'(SEL_CTRL));
    dbgcmp_unit #(.AW(AW), .DW(DW)) u_cmp (
      .clk(clk), .rst(rst),
      .wr_en(wr_stb && sel_me), .wr_sel(wr_addr[SEL_W-1:0]),
      .wr_data(wr_data), .rd_sel(rd_addr[SEL_W-1:0]), .rd_data(unit_rd[u]),
      .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data),
      .bus_fetch(bus_fetch), .bus_write(bus_write), .hit(unit_hit[u])
    );
  end

  always_comb begin
    cap_data = '0;
    if (rd_addr == GCTRL_ADDR)
      cap_data = DW'(ext_en_q);
    else if (rd_addr == STAT_ADDR)
      cap_data = DW'(stat_q);
    else
      for (int u = 0; u < NUM_UNITS; u++)
        if (rd_addr[RA_W-1:SEL_W] == UHI_W'(u)) cap_data = unit_rd[u];
  end

  always_comb begin
    set_v    = {ext_sync && ext_en_q, unit_hit};
    clr_v    = (wr_stb && wr_addr == STAT_ADDR) ? wr_data[NC-1:0] : '0;
    stat_nxt = (stat_q & ~clr_v) | set_v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q   <= '0;
      halt_q   <= 1'b0;
      ext_en_q <= 1'b1;
    end else begin
      stat_q <= stat_nxt;
      halt_q <= |stat_nxt;
      if (wr_stb && wr_addr == GCTRL_ADDR) ext_en_q <= wr_data[0];
    end
  end

  assign halt_req   = halt_q;
  assign halt_cause = stat_q;

  // R11: the halt line follows the recorded causes
  a_r11_halt_is_or: assert property (@(posedge clk) disable iff (rst)
    halt_req == (|halt_cause));
  // R10: without a status write no cause bit falls
  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    !(wr_stb && wr_addr == STAT_ADDR) |=>
      ((halt_cause & $past(halt_cause)) == $past(halt_cause)));
  // R9: an external cause only appears while the request is enabled
  a_r9_ext_gated: assert property (@(posedge clk) disable iff (rst)
    $rose(halt_cause[NC-1]) |-> $past(ext_en_q));
endmodule

// File: tb/dbgcmp_top_tb.sv
module dbgcmp_top_tb;
  localparam int DW = 32;
  localparam int RA = 5;
  localparam int PW = DW + RA + 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic rst = 1'b1;
  logic scan_capture = 0, scan_shift = 0, scan_update = 0, scan_tdi = 0;
  logic scan_tdo;
  logic bus_valid = 0, bus_fetch = 0, bus_write = 0;
  logic [31:0] bus_addr = '0, bus_data = '0;
  logic ext_dbg_req = 0;
  logic halt_req;
  logic [2:0] halt_cause;

  dbgcmp_top u_dut (
    .clk(clk), .rst(rst),
    .scan_capture(scan_capture), .scan_shift(scan_shift),
    .scan_update(scan_update), .scan_tdi(scan_tdi), .scan_tdo(scan_tdo),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_fetch(bus_fetch), .bus_write(bus_write),
    .ext_dbg_req(ext_dbg_req), .halt_req(halt_req), .halt_cause(halt_cause)
  );

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [3:0] exp;
    string      req;
  } exp_t;
  exp_t sb[$];

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // monitor: compare halt outputs against queued expectations
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t it;
      it = sb.pop_front();
      chk(it.req, {28'h0, halt_req, halt_cause}, {28'h0, it.exp});
    end
  end

  function automatic logic [3:0] exp_of(input logic [2:0] c);
    return {|c, c};
  endfunction

  task automatic scan_xfer(input logic [PW-1:0] pkt, input bit do_update,
                           output logic [PW-1:0] got);
    @(negedge clk); scan_capture = 1;
    @(negedge clk); scan_capture = 0;
    for (int i = 0; i < PW; i++) begin
      scan_shift = 1; scan_tdi = pkt[i]; got[i] = scan_tdo;
      @(negedge clk);
    end
    scan_shift = 0;
    if (do_update) begin
      scan_update = 1; @(negedge clk); scan_update = 0;
    end
  endtask

  task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
    logic [PW-1:0] g;
    scan_xfer({1'b1, a, d}, 1'b1, g);
  endtask

  task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
    logic [PW-1:0] g;
    scan_xfer({1'b0, a, 32'h0}, 1'b1, g);
    scan_xfer('0, 1'b0, g);
    d = g[31:0];
  endtask

  task automatic access(input logic f, input logic w, input logic [31:0] a,
                        input logic [31:0] d, input logic [2:0] c, input string req);
    exp_t it;
    @(negedge clk);
    bus_valid = 1; bus_fetch = f; bus_write = w; bus_addr = a; bus_data = d;
    @(posedge clk); #1;
    it.exp = exp_of(c); it.req = req; sb.push_back(it);
    @(negedge clk); bus_valid = 0;
  endtask

  task automatic idle_expect(input logic [2:0] c, input string req);
    exp_t it;
    @(posedge clk); #1;
    it.exp = exp_of(c); it.req = req; sb.push_back(it);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk("R1 halt_req", {31'h0, halt_req}, 32'h0);
    chk("R1 halt_cause", {29'h0, halt_cause}, 32'h0);
    reg_read(5'd16, rd); chk("R1 R3 gctrl reset", rd, 32'h1);
    reg_read(5'd4, rd);  chk("R1 unit0 ctrl reset", rd, 32'h0);
    // R8: disabled units with all-zero registers do not match address 0 fetch
    access(1, 0, 32'h0, 32'h0, 3'b000, "R8 disabled unit0 fetch");
    reg_write(5'd8 + 5'd1, 32'hFFFF_FFFF);
    reg_write(5'd8 + 5'd3, 32'hFFFF_FFFF);
    access(1, 0, 32'h1234_5678, 32'h0, 3'b000, "R8 disabled unit1 all-mask");

    // unit0 as breakpoint on 0x1000..0x100F
    reg_write(5'd0, 32'h0000_1000);
    reg_write(5'd1, 32'h0000_000F);
    reg_write(5'd3, 32'hFFFF_FFFF);
    reg_write(5'd4, 32'h1);
    reg_read(5'd1, rd); chk("R2 R3 amask readback", rd, 32'h0000_000F);
    access(1, 0, 32'h0000_1010, 32'h0, 3'b000, "R4 outside masked range");
    access(0, 0, 32'h0000_1008, 32'h0, 3'b000, "R6 breakpoint ignores data read");
    access(1, 0, 32'h0000_100F, 32'hDEAD_BEEF, 3'b001, "R4 R6 R11 fetch in range");
    idle_expect(3'b001, "R10 cause held");
    idle_expect(3'b001, "R10 cause still held");
    reg_read(5'd17, rd); chk("R10 status readback", rd, 32'h1);
    reg_write(5'd17, 32'h2);
    idle_expect(3'b001, "R10 clearing other bit keeps cause");
    reg_write(5'd17, 32'h1);
    idle_expect(3'b000, "R10 W1C clears unit0");

    // unit1 as write watchpoint at 0x2000, data upper half 0xCAFE
    reg_write(5'd8,  32'h0000_2000);
    reg_write(5'd9,  32'h0);
    reg_write(5'd10, 32'hCAFE_0000);
    reg_write(5'd11, 32'h0000_FFFF);
    reg_write(5'd12, 32'h7);
    access(0, 0, 32'h0000_2000, 32'hCAFE_1234, 3'b000, "R7 read ignored by write wp");
    access(0, 1, 32'h0000_2000, 32'hBEEF_1234, 3'b000, "R5 data mismatch");
    access(0, 1, 32'h0000_2000, 32'hCAFE_9999, 3'b010, "R5 R7 write match");
    reg_write(5'd17, 32'h7);
    idle_expect(3'b000, "R10 clear unit1");
    reg_write(5'd12, 32'hF);
    access(1, 0, 32'h0000_2000, 32'hCAFE_0000, 3'b000, "R7 watchpoint ignores fetch");
    access(0, 0, 32'h0000_2000, 32'hCAFE_0000, 3'b010, "R7 either direction read");
    reg_write(5'd17, 32'h7);
    reg_write(5'd12, 32'hE);
    access(0, 1, 32'h0000_2000, 32'hCAFE_0000, 3'b000, "R8 enable bit cleared");

    // R9: external request timing
    @(negedge clk); ext_dbg_req = 1;
    @(negedge clk); ext_dbg_req = 0;
    chk("R9 ext after 1 edge", {29'h0, halt_cause}, 32'h0);
    @(negedge clk);
    chk("R9 ext after 2 edges", {29'h0, halt_cause}, 32'h0);
    @(negedge clk);
    chk("R9 ext cause set", {28'h0, halt_req, halt_cause}, 32'hC);
    reg_write(5'd16, 32'h0);
    reg_write(5'd17, 32'h7);
    @(negedge clk); ext_dbg_req = 1;
    @(negedge clk); ext_dbg_req = 0;
    repeat (4) @(negedge clk);
    chk("R9 ext disabled", {28'h0, halt_req, halt_cause}, 32'h0);

    @(negedge clk); @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule